// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column access command into the stream of column addresses that an SDRAM burst touches. When the start strobe is sampled it captures a 9-bit starting column, a burst length code and an ordering selection. From the next cycle on it presents one column per clock with a valid flag, and it marks the final beat with a last flag. Each burst stays inside an aligned block whose size is the burst length. The address wraps inside that block, in either counting order or XOR order. A full-page burst walks the whole 512-column page in counting order until it is terminated.

A command sequencer uses the block next to it. The sequencer raises the start strobe when it issues a read or write and can cut a burst short with the terminate input. It can also chain a new burst onto the final beat of the current one with no idle cycle. A combination that cannot be served returns a one-cycle error pulse and no addresses.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: The length code sets the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. `interleave` 0 selects counting order and 1 selects XOR order. A start accepted at clock edge n shows beat 0 (equal to `startCol`) with `colValid` high in the cycle after edge n.
- R2: Beats of a burst appear on consecutive cycles with `colValid` held high and no gaps.
- R3: For a burst of length L = 2^k, column bits k and above equal those of the starting column on every beat, so the address wraps inside the aligned L-column block.
- R4: In counting order, the low k bits of beat i equal (start + i) mod L.
- R5: In XOR order, the low k bits of beat i equal the start's low k bits XOR i.
- R6: `lastBeat` is high only on beat L-1 of a finite burst. In the cycle after that beat, `colValid` is low unless a new burst was accepted.
- R7: A length-1 burst shows exactly `startCol` for one cycle with `lastBeat` high.
- R8: A full-page burst counts through all 9 bits modulo 512, never raises `lastBeat`, and runs until it is terminated.
- R9: When `termStb` is high during a beat, that beat is the final one emitted and `colValid` is low in the next cycle. `termStb` while idle has no effect.
- R10: A start sampled while the final beat is shown is accepted, and the new burst's beat 0 follows in the next cycle. An accepted start takes priority over a terminate at the same edge.
- R11: A start sampled during any beat other than the final one is ignored, and the running burst continues unchanged.
- R12: Codes 4, 5 and 6, and code 7 with `interleave` set, are rejected. The block then gives a one-cycle `cfgError` pulse in the cycle after the start and no `colValid`.
- R13: During and right after reset, `colValid`, `lastBeat` and `cfgError` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Start request for a new burst |
| startCol | input | 9 | Starting column captured with the start |
| lenCode | input | 3 | Burst length code (see R1) |
| interleave | input | 1 | 0 = counting order, 1 = XOR order |
| termStb | input | 1 | Ends the running burst after the current beat |
| colOut | output | 9 | Column address of the current beat |
| colValid | output | 1 | `colOut` holds a burst beat |
| lastBeat | output | 1 | Current beat is the final one of a finite burst |
| cfgError | output | 1 | One-cycle pulse for a rejected start |

## Verification
Every output is a function of registers, so a start sampled at edge n first shows beat 0 in the cycle that follows edge n, and beat i in the cycle after edge n+i. A rejected start shows its error pulse in that same first cycle. A terminate or a chained start sampled at edge m changes the outputs in the cycle after edge m. The bench drives inputs and samples outputs at falling edges, so each expected value is compared exactly one edge after the stimulus that produces it. Expected columns come from a bench function that applies the block-alignment and ordering rules directly.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  typedef struct packed {
    logic load;  // capture a new burst configuration, beat index to zero
    logic step;  // advance to the next beat
  } burstCtl_t;

  localparam logic [2:0] LEN_FULL = 3'd7;
endpackage

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startStb,
  input  logic [2:0] lenCode,
  input  logic      interleave,
  input  logic      termStb,
  output burstCtl_t ctl,
  output logic      busy,
  output logic      lastBeat,
  output logic      cfgError
);
  logic             busyQ, fullQ, errQ;
  logic [COL_W-1:0] remainQ, remainInit;
  logic             cfgBad, accept, lastNow;

  always_comb begin
    cfgBad  = (lenCode inside {3'd4, 3'd5, 3'd6}) || (lenCode == LEN_FULL && interleave);
    lastNow = busyQ && !fullQ && (remainQ == '0);
    accept  = startStb && (!busyQ || lastNow);
    ctl.load = accept && !cfgBad;
    ctl.step = busyQ && !accept && !termStb && !lastNow;
    unique case (lenCode[1:0])
      2'd0:    remainInit = COL_W'(0);
      2'd1:    remainInit = COL_W'(1);
      2'd2:    remainInit = COL_W'(3);
      default: remainInit = COL_W'(7);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      fullQ   <= 1'b0;
      errQ    <= 1'b0;
      remainQ <= '0;
    end else begin
      errQ <= accept && cfgBad;
      if (ctl.load) begin
        busyQ   <= 1'b1;
        fullQ   <= (lenCode == LEN_FULL);
        remainQ <= remainInit;
      end else if (accept || (busyQ && (termStb || lastNow))) begin
        busyQ <= 1'b0;
      end else if (ctl.step && !fullQ) begin
        remainQ <= remainQ - 1'b1;
      end
    end
  end

  assign busy     = busyQ;
  assign lastBeat = lastNow;
  assign cfgError = errQ;
endmodule

// File: rtl/colgen_datapath.sv
module colgen_datapath
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  burstCtl_t        ctl,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  output logic [COL_W-1:0] colAddr
);
  logic [COL_W-1:0] baseQ, maskQ, beatQ, maskN, ordered;
  logic             ilQ;

  always_comb begin
    maskN   = (lenCode == LEN_FULL) ? '1 : COL_W'((4'd1 << lenCode[1:0]) - 4'd1);
    ordered = ilQ ? (baseQ ^ beatQ) : (baseQ + beatQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      maskQ <= '0;
      beatQ <= '0;
      ilQ   <= 1'b0;
    end else if (ctl.load) begin
      baseQ <= startCol;
      maskQ <= maskN;
      beatQ <= '0;
      ilQ   <= interleave;
    end else if (ctl.step) begin
      beatQ <= beatQ + 1'b1;
    end
  end

  for (genvar b = 0; b < COL_W; b++) begin : g_bitSel
    assign colAddr[b] = maskQ[b] ? ordered[b] : baseQ[b];
  end
endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  input  logic             termStb,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat,
  output logic             cfgError
);
  burstCtl_t ctl;

  colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .lenCode(lenCode),
    .interleave(interleave), .termStb(termStb), .ctl(ctl),
    .busy(colValid), .lastBeat(lastBeat), .cfgError(cfgError)
  );

  colgen_datapath #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .colAddr(colOut)
  );
endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             startStb,
  input logic [COL_W-1:0] startCol,
  input logic [2:0]       lenCode,
  input logic             interleave,
  input logic             termStb,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             lastBeat,
  input logic             cfgError
);
  logic goodCfg;
  assign goodCfg = (lenCode inside {3'd0, 3'd1, 3'd2, 3'd3}) || (lenCode == 3'd7 && !interleave);

  a_r1_first_beat: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && !colValid && goodCfg) |=> (colValid && colOut == $past(startCol)));

  a_r2_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !lastBeat && !termStb) |=> colValid);

  a_r6_last_is_valid: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

  a_r9_term_stops: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && termStb && !(startStb && lastBeat)) |=> !colValid);

  a_r12_err_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !colValid);
endmodule

bind sdram_col_burst_gen colgen_checker #(.COL_W(COL_W)) u_chk (.*);

// File: tb/tb_sdram_col_burst_gen.sv
module tb_sdram_col_burst_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       interleave = 1'b0;
  logic       termStb = 1'b0;
  logic [8:0] colOut;
  logic       colValid, lastBeat, cfgError;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sdram_col_burst_gen dut (.*);

  function automatic int lenOf(int code);
    return (code == 7) ? 512 : (1 << code);
  endfunction

  function automatic logic [8:0] expCol(int s, int code, bit il, int i);
    int m = lenOf(code) - 1;
    int low = il ? (s ^ i) : (s + i);
    return 9'(((s & ~m) | (low & m)) & 511);
  endfunction

  task automatic checkOut(bit eV, logic [8:0] eC, bit eL, bit eE, string tag);
    checks++;
    if (colValid !== eV || lastBeat !== eL || cfgError !== eE || (eV && colOut !== eC)) begin
      fails++;
      $display("FAIL %s: got v=%0b col=%0d last=%0b err=%0b, exp v=%0b col=%0d last=%0b err=%0b",
               tag, colValid, colOut, lastBeat, cfgError, eV, eC, eL, eE);
    end
  endtask

  // termBeat < 0: run to natural end (must be >= 0 for full page)
  task automatic runBurst(int s, int code, bit il, int termBeat, string tag);
    int len = lenOf(code);
    int n = (termBeat >= 0 && termBeat < len) ? termBeat + 1 : len;
    @(negedge clk);
    startStb = 1'b1; startCol = 9'(s); lenCode = 3'(code); interleave = il; termStb = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      startStb = 1'b0;
      checkOut(1'b1, expCol(s, code, il, i), (code != 7) && (i == len - 1), 1'b0, tag);
      termStb = (i == termBeat);
    end
    @(negedge clk);
    termStb = 1'b0;
    checkOut(1'b0, '0, 1'b0, 1'b0, {tag, " end"});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    checkOut(1'b0, '0, 1'b0, 1'b0, "R13 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1'b0, '0, 1'b0, 1'b0, "R13 after reset");

    // R9: terminate while idle has no effect
    termStb = 1'b1;
    @(negedge clk);
    termStb = 1'b0;
    checkOut(1'b0, '0, 1'b0, 1'b0, "R9 idle term");

    runBurst(77, 0, 1'b0, -1, "R7 len1");
    runBurst(13, 2, 1'b0, -1, "R4 R3 seq len4 wrap");
    runBurst(5, 3, 1'b1, -1, "R5 il len8");
    runBurst(300, 1, 1'b1, -1, "R1 R5 il len2");
    runBurst(510, 7, 1'b0, 4, "R8 full page wrap");
    runBurst(62, 3, 1'b0, 2, "R9 term mid burst");

    // R12: interleaved full page rejected
    @(negedge clk);
    startStb = 1'b1; startCol = 9'd40; lenCode = 3'd7; interleave = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    checkOut(1'b0, '0, 1'b0, 1'b1, "R12 il full page");
    @(negedge clk);
    checkOut(1'b0, '0, 1'b0, 1'b0, "R12 pulse one cycle");
    // R12: reserved code 5
    startStb = 1'b1; lenCode = 3'd5; interleave = 1'b0;
    @(negedge clk);
    startStb = 1'b0;
    checkOut(1'b0, '0, 1'b0, 1'b1, "R12 reserved code");

    // R10: chained start on last beat, with terminate at same edge
    @(negedge clk);
    startStb = 1'b1; startCol = 9'd6; lenCode = 3'd1; interleave = 1'b0;
    @(negedge clk);
    startStb = 1'b0;
    checkOut(1'b1, 9'd6, 1'b0, 1'b0, "R10 first burst b0");
    @(negedge clk);
    checkOut(1'b1, 9'd7, 1'b1, 1'b0, "R10 first burst last");
    startStb = 1'b1; startCol = 9'd9; lenCode = 3'd2; interleave = 1'b1; termStb = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      startStb = 1'b0; termStb = 1'b0;
      checkOut(1'b1, expCol(9, 2, 1'b1, i), i == 3, 1'b0, "R10 chained burst");
    end
    @(negedge clk);
    checkOut(1'b0, '0, 1'b0, 1'b0, "R6 drop after last");

    // R11: start mid-burst ignored
    startStb = 1'b1; startCol = 9'd100; lenCode = 3'd3; interleave = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      startStb = (i == 2);
      startCol = 9'd400; lenCode = 3'd0; interleave = 1'b1;
      checkOut(1'b1, expCol(100, 3, 1'b0, i), i == 7, 1'b0, "R11 mid start ignored");
    end
    startStb = 1'b0;
    @(negedge clk);
    checkOut(1'b0, '0, 1'b0, 1'b0, "R11 end");

    // Random bursts (R2 R3 R4 R5 R6 R8 R9)
    for (int k = 0; k < 80; k++) begin
      int code = $urandom_range(0, 4);
      bit il;
      int tb;
      if (code == 4) code = 7;
      il = (code == 7) ? 1'b0 : 1'($urandom_range(0, 1));
      if (code == 7) tb = $urandom_range(0, 20);
      else tb = ($urandom_range(0, 3) == 0) ? $urandom_range(0, lenOf(code) - 1) : -1;
      runBurst($urandom_range(0, 511), code, il, tb, "R2 R4 R5 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule